// File: doc/BRIEF.md
# I2C Target GPIO Expander

This block is an I2C target that gives a host eight general-purpose I/O lines. Four byte-wide registers sit behind the bus: a read-only input view, an output latch, a per-bit polarity mask and a per-bit direction mask. The host first writes a command byte that selects one of these registers. Later bytes in the same write go to that register. A read returns the selected register, and keeps returning it for as many bytes as the host clocks.

The block samples SCL and SDA with a system clock that runs at least eight times faster than SCL. START and STOP are recognised as SDA edges while SCL is high. SDA is an open-drain output, and so are the eight pins and the interrupt: each output signal means "pull the line low". A pin pulls low only when it is set as an output and its latch bit is zero.

The input register holds the pin levels captured on the acknowledge clock of a read that targets it, seen through the polarity mask. The interrupt is active low and flags any input pin whose live level differs from that capture.

Top module: `gpio_expander_i2c`

## Requirements
- R1: The target acknowledges only the seven-bit address {4'b0111, addr_i[2:0]}, with the R/W flag as bit 0 of the address byte (0 = write). Any other address gets no acknowledge and no further response until the next START.
- R2: In a write, the first data byte is a command. Its bits [1:0] select the register: 0 input, 1 output, 2 polarity, 3 direction. Every later byte of that write is stored into the selected register. Bytes written while the input register is selected change nothing, and an incomplete byte cut off by STOP is discarded.
- R3: A read returns the register selected last, for every byte of the read. The selection persists across transactions. SDA is driven only during an acknowledge of the target or a data bit being read.
- R4: After reset the output register is 8'hFF, the polarity register is 8'h00, the direction register is 8'hFF (all inputs), the capture is 8'hFF, and SDA, all pins and the interrupt are released.
- R5: pin_oe_o[i] is 1 exactly when direction bit i is 0 (output) and output bit i is 0.
- R6: Reading the input register returns the pins captured on that read's acknowledge clock, XOR the polarity register.
- R7: int_oe_o goes to 1 when a pin configured as input (direction bit 1) differs from its captured value. Pins configured as outputs never raise it.
- R8: A read of the input register clears the interrupt by recapturing the pins.
- R9: The interrupt clears when the pins return to their captured values.
- R10: A STOP returns the target to idle and releases SDA. A repeated START begins a new address phase.
- R11: A host NACK after a read byte ends the read, and SDA stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_i | input | 3 | Strap bits, low three bits of the target address |
| pin_i | input | 8 | Levels of the eight I/O pins |
| pin_oe_o | output | 8 | 1 pulls the matching pin low |
| int_oe_o | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The bench sends address bytes that differ from the target's address only in the fixed nibble or only in the strap bits. A loose comparator would acknowledge one of them. It writes through the input register's slot, and it cuts a data byte short with a STOP. A design that stores either one shows the change when the output, polarity and direction registers are read back. It toggles pins set as outputs, and returns changed pins to their captured levels. The first catches an interrupt that ignores the direction mask, and the second catches one that latches instead of comparing. Reads of several bytes with a final NACK expose a pointer that advances, and an SDA driver that is not released after the NACK.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int DW      = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 3;
  localparam int HI_W    = ADDR_W - STRAP_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } i2c_st_e;

  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_DIR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
  import gpx_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0111
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic               sda_oe_o,
  output logic               wr_en_o,
  output logic               wr_cmd_o,
  output logic [DW-1:0]      wr_data_o,
  output logic               cap_o
);
  localparam int CNT_W = $clog2(DW + 1);

  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  i2c_st_e state_q;
  logic [DW-1:0]    sh_q;
  logic [DW-2:0]    tx_q;
  logic [CNT_W-1:0] cnt_q;
  logic rw_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign wr_data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      tx_q     <= '0;
      cnt_q    <= '0;
      rw_q     <= 1'b0;
      first_q  <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_en_o  <= 1'b0;
      wr_cmd_o <= 1'b0;
      cap_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      cap_o   <= 1'b0;
      if (start_det) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
        first_q  <= 1'b1;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(DW)) begin
              if (sh_q[DW-1:1] == {ADDR_HI, strap_i}) begin
                sda_oe_o <= 1'b1;
                rw_q     <= sh_q[0];
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_rise) begin
              cap_o <= rw_q;
            end else if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q     <= rd_data_i[DW-2:0];
                sda_oe_o <= ~rd_data_i[DW-1];
                state_q  <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(DW)) begin
              sda_oe_o <= 1'b1;
              wr_en_o  <= 1'b1;
              wr_cmd_o <= first_q;
              first_q  <= 1'b0;
              state_q  <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt_q == CNT_W'(DW - 1)) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                sda_oe_o <= ~tx_q[DW-2];
                tx_q     <= {tx_q[DW-3:0], 1'b0};
                cnt_q    <= cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              if (!sda_i) cap_o   <= 1'b1;
              else        state_q <= ST_IDLE;
            end else if (scl_fall) begin
              tx_q     <= rd_data_i[DW-2:0];
              sda_oe_o <= ~rd_data_i[DW-1];
              cnt_q    <= '0;
              state_q  <= ST_RD;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
  // R1
  addr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR_ACK) |-> (sh_q[DW-1:1] == {ADDR_HI, strap_i}));
  // R11
  nack_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK && scl_rise && sda_i) |=> (state_q == ST_IDLE && !sda_oe_o));
  // R3
  sda_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_q inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD}));
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_cmd_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cap_i,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] pin_oe_o,
  output logic          irq_o
);
  reg_sel_e      sel_q;
  logic [DW-1:0] out_q, pol_q, dir_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_IN;
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
      cap_q <= '1;
      irq_o <= 1'b0;
    end else begin
      if (wr_en_i) begin
        if (wr_cmd_i) begin
          sel_q <= reg_sel_e'(wr_data_i[1:0]);
        end else begin
          unique case (sel_q)
            SEL_OUT: out_q <= wr_data_i;
            SEL_POL: pol_q <= wr_data_i;
            SEL_DIR: dir_q <= wr_data_i;
            default: ;
          endcase
        end
      end
      if (cap_i && sel_q == SEL_IN) cap_q <= pin_i;
      irq_o <= |((pin_i ^ cap_q) & dir_q);
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_pad
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_oe_o[i] <= 1'b0;
      else         pin_oe_o[i] <= ~dir_q[i] & ~out_q[i];
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_IN:  rd_data_o = cap_q ^ pol_q;
      SEL_OUT: rd_data_o = out_q;
      SEL_POL: rd_data_o = pol_q;
      default: rd_data_o = dir_q;
    endcase
  end

  // R2
  in_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_cmd_i && sel_q == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));
  // R5
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pin_oe_o & $past(dir_q)) == '0));
  // R7
  irq_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dir_q) == '0) |-> !irq_o);
endmodule

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c
  import gpx_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI     = 4'b0111,
  parameter int              SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] addr_i,
  input  logic [DW-1:0]      pin_i,
  output logic [DW-1:0]      pin_oe_o,
  output logic               int_oe_o
);
  logic          scl_s, sda_s;
  logic [DW-1:0] pin_s, rd_data, wr_data;
  logic          wr_en, wr_cmd, cap;

  gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  gpx_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  gpx_i2c_target #(.ADDR_HI(ADDR_HI)) u_target (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_s),
    .sda_i    (sda_s),
    .strap_i  (addr_i),
    .rd_data_i(rd_data),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en),
    .wr_cmd_o (wr_cmd),
    .wr_data_o(wr_data),
    .cap_o    (cap)
  );

  gpx_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_cmd_i (wr_cmd),
    .wr_data_i(wr_data),
    .cap_i    (cap),
    .pin_i    (pin_s),
    .rd_data_o(rd_data),
    .pin_oe_o (pin_oe_o),
    .irq_o    (int_oe_o)
  );
endmodule

// File: tb/sim_gpio_expander_i2c.sv
module sim_gpio_expander_i2c;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1, sda_h = 1'b1;
  logic [2:0] addr  = 3'b101;
  logic [7:0] ext   = 8'hFF;
  logic       sda_oe, int_oe;
  logic [7:0] pin_oe;
  logic       sda_line;
  logic [7:0] pins;

  assign sda_line = sda_h & ~sda_oe;
  assign pins     = ext & ~pin_oe;

  gpio_expander_i2c u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_i(addr), .pin_i(pins), .pin_oe_o(pin_oe), .int_oe_o(int_oe)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_dir = 8'hFF, m_cap = 8'hFF;

  function automatic logic [7:0] exp_reg(input logic [1:0] p);
    case (p)
      2'd0:    return m_cap ^ m_pol;
      2'd1:    return m_out;
      2'd2:    return m_pol;
      default: return m_dir;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |((pins ^ m_cap) & m_dir);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(2 * Q);
  endtask

  task automatic clk_bit(input bit b, output bit r);
    sda_h = b; tick(Q); scl_h = 1'b1; tick(Q); r = sda_line; tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(!ack, r);
  endtask

  task automatic wr_reg(input logic [1:0] p, input logic [7:0] d);
    bit a;
    i2c_start;
    send_byte({4'b0111, addr, 1'b0}, a);
    send_byte({6'd0, p}, a);
    send_byte(d, a);
    i2c_stop;
    case (p)
      2'd1: m_out = d;
      2'd2: m_pol = d;
      2'd3: m_dir = d;
      default: ;
    endcase
  endtask

  task automatic rd_reg(input logic [1:0] p, input int n,
                        output logic [7:0] first, output logic [7:0] last);
    bit a;
    logic [7:0] b;
    i2c_start;
    send_byte({4'b0111, addr, 1'b0}, a);
    send_byte({6'd0, p}, a);
    i2c_start;
    if (p == 2'd0) m_cap = pins;
    send_byte({4'b0111, addr, 1'b1}, a);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      if (i == 0) first = b;
      last = b;
    end
    i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d0, d1;
    bit a;
    bit r;
    void'($urandom(32'd1234));
    tick(5);
    // R4 reset state at the ports
    chk(sda_oe == 1'b0, "R4", "sda released", sda_oe, 0);
    chk(pin_oe == 8'h00, "R4", "pins released", pin_oe, 0);
    chk(int_oe == 1'b0, "R4", "int released", int_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk(int_oe == 1'b0, "R4", "int released after reset", int_oe, 0);
    for (int p = 1; p < 4; p++) begin
      rd_reg(p[1:0], 1, d0, d1);
      chk(d0 == exp_reg(p[1:0]), "R4", "reset register value", d0, exp_reg(p[1:0]));
    end

    // R1 address matching
    i2c_start; send_byte({4'b0111, 3'b100, 1'b0}, a); i2c_stop;
    chk(!a, "R1", "wrong strap bits acked", a, 0);
    i2c_start; send_byte({4'b0011, addr, 1'b0}, a); i2c_stop;
    chk(!a, "R1", "wrong upper nibble acked", a, 0);
    i2c_start; send_byte({4'b0111, addr, 1'b0}, a); i2c_stop;
    chk(a, "R1", "own address not acked", a, 1);
    addr = 3'b010;
    tick(4);
    i2c_start; send_byte({4'b0111, 3'b010, 1'b1}, a);
    recv_byte(1'b0, d0); i2c_stop;
    chk(a, "R1", "new strap address not acked", a, 1);
    chk(d0 == exp_reg(2'd0), "R3", "pointer kept across transactions", d0, exp_reg(2'd0));

    // R2 multi-byte write lands last byte in selected register
    i2c_start; send_byte({4'b0111, addr, 1'b0}, a);
    send_byte(8'h01, a); send_byte(8'h3C, a); send_byte(8'hC3, a); i2c_stop;
    m_out = 8'hC3;
    rd_reg(2'd1, 3, d0, d1);
    chk(d0 == 8'hC3, "R2", "multi-byte write", d0, 8'hC3);
    chk(d1 == 8'hC3, "R3", "repeated read byte", d1, 8'hC3);

    // R2 writes with input register selected are ignored
    i2c_start; send_byte({4'b0111, addr, 1'b0}, a);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h55, a); i2c_stop;
    rd_reg(2'd1, 1, d0, d1);
    chk(d0 == m_out, "R2", "input write touched output", d0, m_out);
    rd_reg(2'd2, 1, d0, d1);
    chk(d0 == m_pol, "R2", "input write touched polarity", d0, m_pol);
    rd_reg(2'd3, 2, d0, d1);
    chk(d1 == m_dir, "R2", "input write touched direction", d1, m_dir);

    // R10 STOP mid-byte discards the partial byte
    i2c_start; send_byte({4'b0111, addr, 1'b0}, a); send_byte(8'h01, a);
    clk_bit(1'b0, r); clk_bit(1'b0, r); clk_bit(1'b0, r);
    i2c_stop;
    chk(sda_oe == 1'b0, "R10", "sda after stop", sda_oe, 0);
    rd_reg(2'd1, 1, d0, d1);
    chk(d0 == m_out, "R10", "partial byte stored", d0, m_out);

    // R11 NACK ends read, SDA released before STOP
    i2c_start; send_byte({4'b0111, addr, 1'b1}, a);
    recv_byte(1'b0, d0);
    tick(3);
    chk(sda_oe == 1'b0, "R11", "sda after nack", sda_oe, 0);
    i2c_stop;

    // R2 R3 R5 random register traffic
    for (int k = 0; k < 28; k++) begin
      logic [1:0] p;
      logic [7:0] d;
      p = 2'($urandom_range(1, 3));
      d = 8'($urandom);
      wr_reg(p, d);
      rd_reg(p, 2, d0, d1);
      chk(d0 == exp_reg(p), "R2", "random write readback", d0, exp_reg(p));
      chk(d1 == exp_reg(p), "R3", "random repeated read", d1, exp_reg(p));
      chk(pin_oe == (~m_dir & ~m_out), "R5", "pin drive", pin_oe, ~m_dir & ~m_out);
    end

    // R6 R7 R8 R9 input path and interrupt
    wr_reg(2'd3, 8'hFF);
    for (int k = 0; k < 10; k++) begin
      logic [7:0] v;
      logic [7:0] flip;
      wr_reg(2'd2, 8'($urandom));
      ext = 8'($urandom);
      tick(6);
      rd_reg(2'd0, 1, d0, d1);
      chk(d0 == exp_reg(2'd0), "R6", "input read with polarity", d0, exp_reg(2'd0));
      chk(int_oe == 1'b0, "R8", "int after input read", int_oe, 0);
      v = ext;
      flip = 8'(1 << $urandom_range(0, 7));
      ext = v ^ flip;
      tick(6);
      chk(int_oe == exp_irq(), "R7", "int on input change", int_oe, exp_irq());
      ext = v;
      tick(6);
      chk(int_oe == 1'b0, "R9", "int after pins restored", int_oe, 0);
    end

    // R7 output-configured pin does not raise the interrupt
    ext = 8'hFF;
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd3, 8'hFE);
    rd_reg(2'd0, 1, d0, d1);
    ext = 8'hFE;
    tick(6);
    chk(int_oe == 1'b0, "R7", "output pin raised int", int_oe, 0);
    ext = 8'hFD;
    tick(6);
    chk(int_oe == 1'b1, "R7", "input pin change missed", int_oe, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule